// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block keeps in-flight instructions in program order in an eight-slot circular buffer. At issue, an instruction asks for a slot and gets back a tag. Execution units later send back a completion that carries the tag, the result and an exception flag. Completions can arrive in any order.

Only the oldest slot may retire, and only once it has finished. Retiring drives a register-file write (valid, register number, value). This is the only path by which results reach architectural state.

A slot that completes with its exception flag set raises a one-cycle exception pulse when it reaches the oldest position, instead of a register write. That pulse also discards every slot. A separate misprediction flush input pulls the allocation pointer back to the retire pointer, which drops all younger work. Anything already retired stays retired.

Top module: `rob`

## Requirements
- R1: After reset the buffer is empty (`empty`=1, `full`=0), no commit or exception is signalled, and `alloc_tag` is 0.
- R2: An accepted allocation is given `alloc_tag` equal to the current allocation pointer. Tags advance by one for each accepted allocation and wrap from 7 to 0.
- R3: With 8 entries outstanding, `full`=1 and `alloc_ready`=0. An allocation request in that state is dropped, and `alloc_tag` is left unchanged.
- R4: Only the oldest entry may commit, and only after its completion has been written. A finished younger entry never commits ahead of an unfinished older one.
- R5: Each commit presents the entry's destination register and stored result on `commit_reg`/`commit_data` with `commit_valid`=1. Commits come in allocation order, at most one per cycle.
- R6: An allocation and a commit in the same cycle both take effect.
- R7: A `flush` pulse moves the allocation pointer to the retire pointer. The buffer is empty in the next cycle, the discarded entries never commit, and the next tag equals the retire pointer.
- R8: If the oldest entry is finished in a flush cycle, that entry still commits, and the flush discards only the younger entries.
- R9: An oldest entry whose completion carried the exception flag produces `exc_pulse`=1 for one cycle with `commit_valid`=0, and the buffer is empty in the next cycle. No younger entry ever commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request a new entry this cycle |
| alloc_dest | input | 5 | Destination register of the new entry |
| alloc_ready | output | 1 | An entry can be accepted (not full) |
| alloc_tag | output | 3 | Tag the next accepted entry receives |
| wb_valid | input | 1 | Completion write this cycle |
| wb_tag | input | 3 | Entry being completed |
| wb_data | input | 32 | Result value |
| wb_exc | input | 1 | Completion raised an exception |
| flush | input | 1 | Misprediction: drop all uncommitted entries |
| commit_valid | output | 1 | Register-file write this cycle |
| commit_reg | output | 5 | Register written |
| commit_data | output | 32 | Value written |
| exc_pulse | output | 1 | Oldest entry retired with an exception |
| full | output | 1 | All 8 entries in flight |
| empty | output | 1 | No entries in flight |

## Verification
The embedded assertions watch pointer behaviour on every cycle:
- the occupancy never exceeds the depth;
- a full buffer with a stalled head never moves its allocation pointer;
- every flush or exception pulse leaves the buffer empty one cycle later;
- a commit advances the retire pointer by exactly one.

Some properties need a scoreboard and are shown only by the bench's scenarios:
- retirement order against out-of-order completion;
- the values that reach the register port;
- the tags handed out after a flush;
- that discarded entries never reappear.

// File: rtl/rob.sv
module rob #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [REG_W-1:0]  alloc_dest,
  output logic              alloc_ready,
  output logic [$clog2(DEPTH)-1:0] alloc_tag,
  input  logic              wb_valid,
  input  logic [$clog2(DEPTH)-1:0] wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_exc,
  input  logic              flush,
  output logic              commit_valid,
  output logic [REG_W-1:0]  commit_reg,
  output logic [DATA_W-1:0] commit_data,
  output logic              exc_pulse,
  output logic              full,
  output logic              empty
);
  localparam int TW = $clog2(DEPTH);
  localparam int PW = TW + 1;

  logic [PW-1:0]     head, tail;
  logic [REG_W-1:0]  dest_q [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];
  logic [DEPTH-1:0]  done_q, exc_q;

  wire [TW-1:0] hidx = head[TW-1:0];
  wire [TW-1:0] tidx = tail[TW-1:0];
  wire [PW-1:0] count = tail - head;

  assign full        = (count == PW'(DEPTH));
  assign empty       = (head == tail);
  assign alloc_ready = !full;
  assign alloc_tag   = tidx;

  wire head_rdy = !empty && done_q[hidx];
  assign commit_valid = head_rdy && !exc_q[hidx];
  assign exc_pulse    = head_rdy &&  exc_q[hidx];
  assign commit_reg   = dest_q[hidx];
  assign commit_data  = val_q[hidx];

  wire do_alloc = alloc_valid && !full && !flush && !exc_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (head_rdy) head <= head + 1'b1;
      if (exc_pulse)     tail <= head + 1'b1;
      else if (flush)    tail <= head + PW'(head_rdy);
      else if (do_alloc) tail <= tail + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        done_q[i] <= 1'b0;
        exc_q[i]  <= 1'b0;
        dest_q[i] <= '0;
        val_q[i]  <= '0;
      end else if (do_alloc && tidx == TW'(i)) begin
        done_q[i] <= 1'b0;
        exc_q[i]  <= 1'b0;
        dest_q[i] <= alloc_dest;
      end else if (wb_valid && wb_tag == TW'(i)) begin
        done_q[i] <= 1'b1;
        exc_q[i]  <= wb_exc;
        val_q[i]  <= wb_data;
      end
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PW'(DEPTH));
  assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !head_rdy && !flush) |=> $stable(tail));
  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  assert_exc_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |=> (empty && !exc_pulse));
  assert_head_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> (head == $past(head) + 1'b1));
endmodule

// File: tb/test_rob.sv
module test_rob;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        alloc_valid = 0, wb_valid = 0, wb_exc = 0, flush = 0;
  logic [4:0]  alloc_dest = 0;
  logic [2:0]  wb_tag = 0;
  logic [31:0] wb_data = 0;
  logic        alloc_ready, commit_valid, exc_pulse, full, empty;
  logic [2:0]  alloc_tag;
  logic [4:0]  commit_reg;
  logic [31:0] commit_data;

  rob i_rob (.clk, .rst_n, .alloc_valid, .alloc_dest, .alloc_ready, .alloc_tag,
    .wb_valid, .wb_tag, .wb_data, .wb_exc, .flush, .commit_valid, .commit_reg,
    .commit_data, .exc_pulse, .full, .empty);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int bhead = 0, btail = 0, commits = 0;
  int q[$];
  logic [4:0]  e_dest [8];
  logic [31:0] e_data [8];
  logic        e_exc  [8];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && (commit_valid || exc_pulse)) begin
    int t;
    if (q.size() == 0) begin
      chk(0, "R7 unexpected retire", commit_reg, -1);
    end else begin
      t = q.pop_front();
      chk(t == bhead % 8, "R4 retire order", bhead % 8, t);
      chk(exc_pulse == e_exc[t], "R9 exception flag", exc_pulse, e_exc[t]);
      if (commit_valid) begin
        chk(commit_reg == e_dest[t], "R5 commit reg", commit_reg, e_dest[t]);
        chk(commit_data == e_data[t], "R5 commit data", commit_data, e_data[t]);
        commits++;
      end
      bhead++;
      if (exc_pulse) begin
        q.delete();
        btail = bhead;
      end
    end
  end

  task automatic idle();
    @(negedge clk); #1;
    alloc_valid = 0; wb_valid = 0; flush = 0; wb_exc = 0;
  endtask

  task automatic alloc(input logic [4:0] d, input logic [31:0] v, output int tag);
    idle();
    while (!alloc_ready) idle();
    chk(alloc_tag == btail % 8, "R2 tag", alloc_tag, btail % 8);
    tag = btail % 8;
    e_dest[tag] = d; e_data[tag] = v; e_exc[tag] = 0;
    alloc_valid = 1; alloc_dest = d;
    q.push_back(tag);
    btail++;
  endtask

  task automatic wb(input int tag, input bit ex);
    idle();
    e_exc[tag] = ex;
    wb_valid = 1; wb_tag = 3'(tag); wb_data = e_data[tag]; wb_exc = ex;
  endtask

  task automatic do_flush();
    idle();
    flush = 1;
    q.delete();
    btail = bhead;
  endtask

  initial begin
    #(PERIOD*100000);
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int tags[8];
    int t, a, b, c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(empty && !full && !commit_valid && !exc_pulse, "R1 reset status", {empty, full}, 2);
    chk(alloc_tag == 0, "R1 reset tag", alloc_tag, 0);

    for (int i = 0; i < 8; i++) alloc(5'(i + 1), 32'(100 + i * 7), tags[i]);
    idle(); #1;
    chk(full && !alloc_ready, "R3 full", full, 1);
    alloc_valid = 1; alloc_dest = 5'd30;
    idle(); #1;
    chk(full && alloc_tag == 0, "R3 refused alloc", alloc_tag, 0);

    for (int i = 7; i >= 1; i--) begin
      wb(tags[i], 0);
      chk(!commit_valid, "R4 head not done", commit_valid, 0);
    end
    idle();
    chk(!commit_valid, "R4 stall before head done", commit_valid, 0);
    wb(tags[0], 0);
    repeat (10) idle();
    chk(commits == 8 && empty, "R5 all drained", commits, 8);

    alloc(5'd9, 32'hA5A5, a);
    wb(a, 0);
    c0 = commits;
    alloc(5'd10, 32'h1234, b);
    chk(commit_valid, "R6 commit in alloc cycle", commit_valid, 1);
    idle(); #1;
    chk(!empty && alloc_tag == (btail % 8) && commits == c0 + 1, "R6 both proceed", alloc_tag, btail % 8);
    wb(b, 0);
    repeat (3) idle();
    chk(empty, "R6 drained", empty, 1);

    alloc(5'd11, 32'd1, a);
    alloc(5'd12, 32'd2, b);
    alloc(5'd13, 32'd3, t);
    wb(b, 0);
    wb(t, 0);
    do_flush();
    idle(); #1;
    chk(empty, "R7 empty after flush", empty, 1);
    chk(alloc_tag == bhead % 8, "R7 tag back to head", alloc_tag, bhead % 8);
    repeat (4) idle();

    alloc(5'd14, 32'd77, a);
    alloc(5'd15, 32'd88, b);
    wb(a, 0);
    c0 = commits;
    idle();
    flush = 1;
    chk(commit_valid, "R8 head ready at flush", commit_valid, 1);
    #1;
    q.delete();
    btail = bhead;
    idle(); #1;
    chk(empty && commits == c0 + 1, "R8 commit kept", commits, c0 + 1);
    wb(b, 0);
    repeat (3) idle();

    alloc(5'd16, 32'd5, a);
    alloc(5'd17, 32'd6, b);
    alloc(5'd18, 32'd7, t);
    wb(t, 0);
    wb(b, 1);
    c0 = commits;
    wb(a, 0);
    idle();
    idle();
    chk(exc_pulse && !commit_valid, "R9 exc pulse", exc_pulse, 1);
    idle(); #1;
    chk(empty && !exc_pulse, "R9 emptied", empty, 1);
    repeat (4) idle();
    chk(commits == c0 + 1, "R9 younger dropped", commits, c0 + 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule